// File: doc/BRIEF.md
# Two-Pixel Packed RGB to YUV Converter

This block turns a stream of packed pixel pairs into luma and chroma bytes using fixed-point arithmetic. Each input transfer is one 64-bit word that carries two RGB pixels in an interleaved, zero-padded byte order. Each output transfer carries a luma byte for each of the two pixels and a single chroma pair (U, V) taken from the first pixel. This halves the horizontal chroma rate.

Each output channel is a three-term dot product of the pixel's unsigned components with signed fractional coefficients. The coefficients are stored as integers scaled by 2^(COEF_W-1). The sum is rescaled by a truncating arithmetic right shift. The chroma channels then receive a mid-scale offset, and every result is clamped in two steps. Both ends of the stream use valid/ready handshakes. A small write port updates the nine coefficients. A write waits until the pipeline is empty, so no output is computed from a mix of old and new coefficients.

Top module: `pyuv_pair_conv`

## Requirements
- R1: Input byte lanes: byte 0 = R of pixel A, byte 1 = G of pixel A, byte 2 = B of pixel B, byte 4 = B of pixel A, byte 6 = R of pixel B, byte 7 = G of pixel B. Bytes 3 and 5 are padding, and their values have no effect on any output.
- R2: Each channel value is floor((cR*R + cG*G + cB*B) / 32768). The pixel bytes are unsigned, the coefficients are signed 16-bit, and the shift truncates toward minus infinity (a sum of -1 yields -1).
- R3: The U and V channels get +128 after the shift. The Y channels get no offset.
- R4: Each result is first clamped to the signed 16-bit range and then to 0..255. Negative results give 0, and results above 255 give 255.
- R5: `out_y0` is the luma of pixel A and `out_y1` is the luma of pixel B. `out_u` and `out_v` are computed from pixel A only.
- R6: After reset `out_valid` is 0 and the coefficients are Q15 Y=(9798, 19235, 3736), U=(-5538, -10846, 16384), V=(16384, -13730, -2654), listed in R, G, B order.
- R7: While `out_valid` is high and `out_ready` is low, all outputs hold steady. `in_ready` is high only when the output register is empty or is being drained. No accepted word is lost or duplicated.
- R8: When `out_ready` is held high, a word accepted at a clock edge appears on the outputs after the third rising edge, counting the accepting edge as the first. Back-to-back words are accepted on every cycle.
- R9: A coefficient write to address channel*3+component (channel Y=0, U=1, V=2; component R=0, G=1, B=2) applies to every word accepted after it. Writes to addresses 9 and above change nothing.
- R10: While `cfg_we` is high, `in_ready` is low. The write takes place, and `cfg_ack` is high, only in a cycle where no word is in flight and the output register is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Input word may be taken |
| in_data | input | 64 | Packed pixel pair |
| out_valid | output | 1 | Output set valid |
| out_ready | input | 1 | Downstream takes the output |
| out_y0 | output | 8 | Luma, pixel A |
| out_y1 | output | 8 | Luma, pixel B |
| out_u | output | 8 | Chroma U, pixel A |
| out_v | output | 8 | Chroma V, pixel A |
| cfg_we | input | 1 | Coefficient write request |
| cfg_addr | input | 4 | Coefficient index |
| cfg_wdata | input | 16 | Signed coefficient value |
| cfg_ack | output | 1 | Write performed this cycle |

## Verification
The bench builds the block with its default parameters: 8-bit components, 16-bit Q15 coefficients and a 32-bit accumulator. At these widths, extreme coefficients such as -32768 and 32767 drive the sums far past the byte range in both directions, which exercises both clamp directions. Single-unit coefficients expose truncation of negative fractions. Random coefficient rewrites during a live stream test the drain interlock against outputs that would otherwise mix coefficient sets.

// File: rtl/pyuv_pkg.sv
package pyuv_pkg;
   localparam int unsigned NUM_CH   = 3;
   localparam int unsigned NUM_COMP = 3;
   localparam int unsigned NUM_COEF = NUM_CH * NUM_COMP;

   typedef enum logic [1:0] {CH_Y = 2'd0, CH_U = 2'd1, CH_V = 2'd2} chan_e;

   // Default matrix, Q15, index = channel*3 + component
   function automatic logic signed [15:0] q15_default(input int idx);
      case (idx)
         0: q15_default = 16'sd9798;
         1: q15_default = 16'sd19235;
         2: q15_default = 16'sd3736;
         3: q15_default = -16'sd5538;
         4: q15_default = -16'sd10846;
         5: q15_default = 16'sd16384;
         6: q15_default = 16'sd16384;
         7: q15_default = -16'sd13730;
         default: q15_default = -16'sd2654;
      endcase
   endfunction
endpackage

// File: rtl/pyuv_coef_bank.sv
module pyuv_coef_bank #(
   parameter int unsigned COEF_W = 16,
   parameter int unsigned ADDR_W = 4
) (
   input  logic                                         clk,
   input  logic                                         rst_n,
   input  logic                                         wr_en,
   input  logic [ADDR_W-1:0]                            wr_addr,
   input  logic [COEF_W-1:0]                            wr_data,
   output logic [pyuv_pkg::NUM_COEF-1:0][COEF_W-1:0]    coefs
);
   localparam int unsigned N = pyuv_pkg::NUM_COEF;

   if (COEF_W < 16) begin : g_bad_coef_w
      $error("COEF_W must be at least 16");
   end
   if ((2 ** ADDR_W) < N) begin : g_bad_addr_w
      $error("ADDR_W too narrow for coefficient count");
   end

   for (genvar i = 0; i < N; i++) begin : g_coef
      localparam logic signed [COEF_W-1:0] RST_VAL =
         COEF_W'(pyuv_pkg::q15_default(i)) <<< (COEF_W - 16);
      always_ff @(posedge clk) begin
         if (!rst_n)
            coefs[i] <= RST_VAL;
         else if (wr_en && (wr_addr == ADDR_W'(i)))
            coefs[i] <= wr_data;
      end
   end

   AST_COEF_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en || wr_addr >= ADDR_W'(N)) |=> $stable(coefs)); // R9
endmodule

// File: rtl/pyuv_dot3.sv
module pyuv_dot3 #(
   parameter int unsigned PIX_W  = 8,
   parameter int unsigned COEF_W = 16,
   parameter int unsigned ACC_W  = 32,
   parameter int unsigned FRAC   = 15,
   parameter int unsigned RES_W  = ACC_W - FRAC
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          en,
   input  logic [2:0][PIX_W-1:0]         px,
   input  logic [2:0][COEF_W-1:0]        cf,
   output logic signed [RES_W-1:0]       res
);
   localparam int unsigned PROD_W = PIX_W + 1 + COEF_W;

   if (ACC_W < PROD_W + 2) begin : g_bad_acc
      $error("ACC_W cannot hold a three-term sum");
   end

   logic signed [PROD_W-1:0] prod_q [3];
   logic signed [ACC_W-1:0]  sum_c;

   // Stage 1: products of zero-extended pixel and signed coefficient
   for (genvar k = 0; k < 3; k++) begin : g_mul
      always_ff @(posedge clk) begin
         if (!rst_n)
            prod_q[k] <= '0;
         else if (en)
            prod_q[k] <= $signed({1'b0, px[k]}) * $signed(cf[k]);
      end
   end

   always_comb
      sum_c = ACC_W'(prod_q[0]) + ACC_W'(prod_q[1]) + ACC_W'(prod_q[2]);

   // Stage 2: accumulate and truncating arithmetic rescale
   always_ff @(posedge clk) begin
      if (!rst_n)
         res <= '0;
      else if (en)
         res <= RES_W'(sum_c >>> FRAC);
   end
endmodule

// File: rtl/pyuv_clip.sv
module pyuv_clip #(
   parameter int unsigned IN_W  = 17,
   parameter int unsigned MID_W = 16,
   parameter int unsigned OUT_W = 8,
   parameter int          OFS   = 0
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    en,
   input  logic signed [IN_W-1:0]  din,
   output logic [OUT_W-1:0]        dout
);
   localparam int MID_MAX = (2 ** (MID_W - 1)) - 1;
   localparam int MID_MIN = -(2 ** (MID_W - 1));
   localparam int OUT_MAX = (2 ** OUT_W) - 1;

   if (IN_W > 30 || MID_W > 30 || OUT_W >= MID_W) begin : g_bad_w
      $error("pyuv_clip width parameters out of range");
   end

   logic signed [31:0] biased, mid;
   logic [OUT_W-1:0]   clipped;

   always_comb begin
      biased = {{(32 - IN_W){din[IN_W-1]}}, din} + 32'(OFS);
      if (biased > MID_MAX)      mid = MID_MAX;
      else if (biased < MID_MIN) mid = MID_MIN;
      else                       mid = biased;
      if (mid < 0)               clipped = '0;
      else if (mid > OUT_MAX)    clipped = OUT_W'(OUT_MAX);
      else                       clipped = OUT_W'(mid);
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         dout <= '0;
      else if (en)
         dout <= clipped;
   end

   AST_CLIP_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (en && ($signed(din) + OFS < 0)) |=> (dout == '0)); // R4
   AST_CLIP_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (en && ($signed(din) + OFS > OUT_MAX)) |=> (dout == OUT_W'(OUT_MAX))); // R4
endmodule

// File: rtl/pyuv_pair_conv.sv
module pyuv_pair_conv #(
   parameter int unsigned PIX_W  = 8,
   parameter int unsigned COEF_W = 16,
   parameter int unsigned ACC_W  = 32,
   parameter int unsigned SAT_W  = 16,
   parameter int unsigned ADDR_W = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                in_valid,
   output logic                in_ready,
   input  logic [8*PIX_W-1:0]  in_data,
   output logic                out_valid,
   input  logic                out_ready,
   output logic [PIX_W-1:0]    out_y0,
   output logic [PIX_W-1:0]    out_y1,
   output logic [PIX_W-1:0]    out_u,
   output logic [PIX_W-1:0]    out_v,
   input  logic                cfg_we,
   input  logic [ADDR_W-1:0]   cfg_addr,
   input  logic [COEF_W-1:0]   cfg_wdata,
   output logic                cfg_ack
);
   localparam int unsigned FRAC   = COEF_W - 1;
   localparam int unsigned RES_W  = ACC_W - FRAC;
   localparam int          C_OFS  = 2 ** (PIX_W - 1);
   localparam int unsigned LANES  = 4;

   // Byte positions inside the packed word: [pixel][component]
   localparam int unsigned BYTE_R [2] = '{0, 6};
   localparam int unsigned BYTE_G [2] = '{1, 7};
   localparam int unsigned BYTE_B [2] = '{4, 2};

   logic [pyuv_pkg::NUM_COEF-1:0][COEF_W-1:0] coefs;
   logic [PIX_W-1:0] lane_out [LANES];
   logic v1, v2, v3, adv, fire, pipe_empty;

   assign adv        = !v3 || out_ready;
   assign in_ready   = adv && !cfg_we;
   assign fire       = in_valid && in_ready;
   assign pipe_empty = !v1 && !v2 && !v3;
   assign cfg_ack    = cfg_we && pipe_empty;
   assign out_valid  = v3;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         v1 <= 1'b0;
         v2 <= 1'b0;
         v3 <= 1'b0;
      end else if (adv) begin
         v1 <= fire;
         v2 <= v1;
         v3 <= v2;
      end
   end

   pyuv_coef_bank #(.COEF_W(COEF_W), .ADDR_W(ADDR_W)) u_bank (
      .clk(clk), .rst_n(rst_n), .wr_en(cfg_ack), .wr_addr(cfg_addr),
      .wr_data(cfg_wdata), .coefs(coefs)
   );

   // Lane 0: Y of pixel A, lane 1: Y of pixel B, lanes 2/3: U/V of pixel A
   for (genvar l = 0; l < LANES; l++) begin : g_lane
      localparam int unsigned CH = (l < 2) ? 0 : l - 1;
      localparam int unsigned PX = (l == 1) ? 1 : 0;
      localparam int          LANE_OFS = (CH == 0) ? 0 : C_OFS;

      logic [2:0][PIX_W-1:0]  px;
      logic [2:0][COEF_W-1:0] cf;
      logic signed [RES_W-1:0] res;

      assign px = {in_data[BYTE_B[PX]*PIX_W +: PIX_W],
                   in_data[BYTE_G[PX]*PIX_W +: PIX_W],
                   in_data[BYTE_R[PX]*PIX_W +: PIX_W]};
      assign cf = {coefs[CH*3+2], coefs[CH*3+1], coefs[CH*3]};

      pyuv_dot3 #(.PIX_W(PIX_W), .COEF_W(COEF_W), .ACC_W(ACC_W),
                  .FRAC(FRAC), .RES_W(RES_W)) u_dot (
         .clk(clk), .rst_n(rst_n), .en(adv), .px(px), .cf(cf), .res(res)
      );

      pyuv_clip #(.IN_W(RES_W), .MID_W(SAT_W), .OUT_W(PIX_W),
                  .OFS(LANE_OFS)) u_clip (
         .clk(clk), .rst_n(rst_n), .en(adv), .din(res), .dout(lane_out[l])
      );
   end

   assign out_y0 = lane_out[0];
   assign out_y1 = lane_out[1];
   assign out_u  = lane_out[2];
   assign out_v  = lane_out[3];

   AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable({out_y0, out_y1, out_u, out_v}))); // R7
   AST_CFG_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_ack |-> (!out_valid && !in_ready)); // R10
   AST_CFG_BLOCKS_IN: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && !cfg_ack) |=> !$past(fire)); // R10
endmodule

// File: tb/pyuv_pair_conv_tb_top.sv
module pyuv_pair_conv_tb_top;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        in_valid, in_ready, out_valid, out_ready;
   logic [63:0] in_data;
   logic [7:0]  out_y0, out_y1, out_u, out_v;
   logic        cfg_we, cfg_ack;
   logic [3:0]  cfg_addr;
   logic [15:0] cfg_wdata;

   always #5 clk = ~clk;

   pyuv_pair_conv dut_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
      .out_y0(out_y0), .out_y1(out_y1), .out_u(out_u), .out_v(out_v),
      .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_ack(cfg_ack)
   );

   int n_run = 0, n_fail = 0;
   bit finished = 0;
   int mc [9];
   logic [31:0] expq [$];
   logic [31:0] last_pop, hold_val;
   bit hold_pend = 0, ack_seen, popped;

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic int chan(input int r, input int g, input int b,
                               input int cr, input int cg, input int cb, input int ofs);
      int s;
      s = (cr * r + cg * g + cb * b) >>> 15;
      s = s + ofs;
      if (s > 32767) s = 32767;
      if (s < -32768) s = -32768;
      if (s < 0) s = 0;
      if (s > 255) s = 255;
      return s;
   endfunction

   function automatic logic [31:0] expect_word(input logic [63:0] d);
      int ra, ga, ba, rb, gb, bb, y0, y1, u, v;
      ra = d[7:0];   ga = d[15:8];  ba = d[39:32];
      rb = d[55:48]; gb = d[63:56]; bb = d[23:16];
      y0 = chan(ra, ga, ba, mc[0], mc[1], mc[2], 0);
      y1 = chan(rb, gb, bb, mc[0], mc[1], mc[2], 0);
      u  = chan(ra, ga, ba, mc[3], mc[4], mc[5], 128);
      v  = chan(ra, ga, ba, mc[6], mc[7], mc[8], 128);
      return {y0[7:0], y1[7:0], u[7:0], v[7:0]};
   endfunction

   function automatic logic [63:0] pack(input int ra, input int ga, input int ba,
                                        input int rb, input int gb, input int bb,
                                        input logic [15:0] pad);
      return {gb[7:0], rb[7:0], pad[15:8], ba[7:0], pad[7:0], bb[7:0], ga[7:0], ra[7:0]};
   endfunction

   task automatic load_defaults();
      mc = '{9798, 19235, 3736, -5538, -10846, 16384, 16384, -13730, -2654};
   endtask

   // One cycle: inputs already set after a falling edge
   task automatic cyc();
      logic [31:0] cur, e;
      #1;
      cur = {out_y0, out_y1, out_u, out_v};
      popped = 0;
      if (hold_pend)
         check(out_valid && cur == hold_val, "R7", "held output", cur, hold_val);
      hold_pend = out_valid && !out_ready;
      hold_val  = cur;
      if (out_valid && !out_ready)
         check(!in_ready, "R7", "in_ready under backpressure", in_ready, 0);
      if (out_valid && out_ready) begin
         if (expq.size() == 0) begin
            check(0, "R7", "unexpected output", cur, 0);
         end else begin
            e = expq.pop_front();
            check(cur == e, "R2 R5", "output set", cur, e);
         end
         last_pop = cur;
         popped = 1;
      end
      if (cfg_we)
         check(!in_ready, "R10", "in_ready during write request", in_ready, 0);
      if (cfg_ack) begin
         check(expq.size() == 0 && !out_valid, "R10", "write with data in flight",
               expq.size(), 0);
         if (cfg_addr < 9) mc[cfg_addr] = int'($signed(cfg_wdata));
         ack_seen = 1;
      end
      if (in_valid && in_ready) expq.push_back(expect_word(in_data));
      @(negedge clk);
   endtask

   task automatic cfg_write(input int addr, input int val);
      cfg_we = 1; cfg_addr = 4'(addr); cfg_wdata = 16'(val);
      in_valid = 0; out_ready = 1; ack_seen = 0;
      for (int i = 0; i < 20 && !ack_seen; i++) cyc();
      check(ack_seen, "R10", "write acknowledged", ack_seen, 1);
      cfg_we = 0;
   endtask

   task automatic send(input logic [63:0] d);
      in_valid = 1; in_data = d; out_ready = 1;
      cyc();
      in_valid = 0;
   endtask

   task automatic drain();
      in_valid = 0; out_ready = 1;
      for (int i = 0; i < 6; i++) cyc();
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1;
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   endtask

   initial begin
      #2_000_000;
      n_run++; n_fail++;
      $display("FAIL watchdog expired actual=1 expected=0");
      summary();
   end

   initial begin
      int lat;
      void'($urandom(32'd20240611));
      load_defaults();
      rst_n = 0; in_valid = 0; out_ready = 0; in_data = '0;
      cfg_we = 0; cfg_addr = '0; cfg_wdata = '0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      #1;
      check(!out_valid, "R6", "out_valid after reset", out_valid, 0);
      check(in_ready, "R7", "in_ready after reset", in_ready, 1);
      @(negedge clk);

      // R6 default matrix: white and black
      send(pack(255, 255, 255, 255, 255, 255, 16'h0)); drain();
      check(last_pop == 32'hFFFF8080, "R6", "white pair", last_pop, 32'hFFFF8080);
      send(pack(0, 0, 0, 0, 0, 0, 16'h0)); drain();
      check(last_pop == 32'h00008080, "R3", "black pair, chroma offset", last_pop, 32'h00008080);
      // R1 R5: red A, blue B, nonzero padding
      send(pack(255, 0, 0, 0, 0, 255, 16'hAA55)); drain();
      check(last_pop == {8'd76, 8'd29, 8'd84, 8'd255}, "R1 R5", "red/blue pair",
            last_pop, {8'd76, 8'd29, 8'd84, 8'd255});

      // R2 truncation of negative and positive fractions
      cfg_write(3, -1); cfg_write(4, 0); cfg_write(5, 0);
      cfg_write(0, 16384); cfg_write(1, 0); cfg_write(2, 0);
      send(pack(3, 0, 0, 1, 0, 0, 16'hFFFF)); drain();
      check(last_pop == {8'd1, 8'd0, 8'd127, 8'd129}, "R2", "truncating shift",
            last_pop, {8'd1, 8'd0, 8'd127, 8'd129});

      // R4 saturation both ways
      cfg_write(0, 32767); cfg_write(1, 32767); cfg_write(3, -32768);
      load_defaults(); mc[0] = 32767; mc[1] = 32767; mc[2] = 0;
      mc[3] = -32768; mc[4] = 0; mc[5] = 0;
      send(pack(255, 255, 0, 0, 0, 0, 16'h0)); drain();
      check(last_pop == {8'd255, 8'd0, 8'd0, 8'd148}, "R4", "clamp high/low",
            last_pop, {8'd255, 8'd0, 8'd0, 8'd148});

      // R9 out-of-range addresses ignored
      cfg_write(9, 16'h1234); cfg_write(15, 16'h7FFF);
      send(pack(255, 255, 0, 0, 0, 0, 16'h0)); drain();
      check(last_pop == {8'd255, 8'd0, 8'd0, 8'd148}, "R9", "ignored address",
            last_pop, {8'd255, 8'd0, 8'd0, 8'd148});

      // restore default matrix
      for (int i = 0; i < 9; i++) begin
         int dv [9];
         dv = '{9798, 19235, 3736, -5538, -10846, 16384, 16384, -13730, -2654};
         cfg_write(i, dv[i]);
      end

      // R8 latency
      send(pack(10, 20, 30, 40, 50, 60, 16'h0));
      lat = 0;
      for (int i = 1; i <= 6 && lat == 0; i++) begin
         cyc();
         if (popped) lat = i;
      end
      check(lat == 3, "R8", "latency in cycles", lat, 3);
      drain();

      // R8 throughput: eight back-to-back words
      out_ready = 1;
      for (int i = 0; i < 8; i++) begin
         in_valid = 1; in_data = {$urandom(), $urandom()};
         #1;
         check(in_ready, "R8", "back-to-back accept", in_ready, 1);
         #0;
         cyc_wrap();
      end
      drain();

      // R7 backpressure: fill then release
      out_ready = 0;
      for (int i = 0; i < 6; i++) begin
         in_valid = 1; in_data = {$urandom(), $urandom()};
         cyc();
      end
      drain();

      // R10 write while words are in flight
      send({$urandom(), $urandom()});
      send({$urandom(), $urandom()});
      cfg_write(2, 4000);
      drain();

      // random phase
      for (int c = 0; c < 4000; c++) begin
         if ($urandom_range(0, 199) == 0) begin
            int val;
            val = ($urandom_range(0, 1) == 1) ? int'($urandom_range(0, 65535)) - 32768
                                              : int'($urandom_range(0, 40000)) - 20000;
            cfg_write($urandom_range(0, 15), val);
         end
         in_valid  = ($urandom_range(0, 9) < 7);
         out_ready = ($urandom_range(0, 3) != 0);
         in_data   = {$urandom(), $urandom()};
         if ($urandom_range(0, 15) == 0) in_data[31:0] = '0;
         if ($urandom_range(0, 15) == 0) in_data = '1;
         cyc();
      end
      drain();
      check(expq.size() == 0, "R7", "words left unreturned", expq.size(), 0);
      summary();
   end

   task automatic cyc_wrap();
      cyc();
   endtask
endmodule